// File: doc/BRIEF.md
# PCI Shared Interrupt Line Router

This block steers the level-sensitive INTx pins of the devices on a PCI bus onto the sixteen inputs of a legacy interrupt controller. First it rotates each device's four pins by the device's slot number, which gives four shared interrupt lines, PIRQ0 to PIRQ3. Each shared line then passes through a byte-wide steering register that picks one controller input for it, or none. More than one shared line may be steered to the same controller input. That input then carries the OR of their levels.

Firmware programs the steering bytes through a byte-wide register port. The port decodes four consecutive configuration offsets. All output lines are registered. Every output is rebuilt each clock from the current input levels and steering bytes, so a change of steering takes effect at once, with no stale level left on a line that lost its source.

Top module: `pirq_intx_router`

## Requirements
- R1: After reset, all four steering registers read 0x80 and every bit of `irq_line` is 0.
- R2: The steering register of PIRQp is at byte offset 0x60 + p. A read returns the last byte written there, all eight bits unchanged, including values that disable the line.
- R3: A steering byte of 16 or more (decimal) disables its PIRQ, so that PIRQ drives no output line. A byte from 0 to 15 selects output line `irq_line[value]`.
- R4: Each output line is the OR of the levels of every enabled PIRQ whose steering byte selects that line. Several PIRQs on one line hold it high while any of them is high.
- R5: Input bit `dev_intx[s*4 + i]` is pin i (0 = INTA to 3 = INTD) of the device in slot s. It drives PIRQ number (i + s - 1) mod 4, so slot 0 pin 0 maps to PIRQ3 and slot 1 pin 0 maps to PIRQ0.
- R6: A change on `dev_intx` shows on `irq_line` after the next rising clock edge. A steering write takes effect at the edge where `cfg_wr_en` is sampled, and the outputs follow at the edge after that.
- R7: Writes to offsets outside 0x60 to 0x63 change no steering register, and reads there return 0x00.
- R8: When a PIRQ is re-steered, its old line drops and its new line rises on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 8 | Register byte offset for reads and writes |
| cfg_wr_en | input | 1 | Write strobe, one byte per cycle |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_data | output | 8 | Read data for `cfg_addr`, combinational |
| dev_intx | input | 32 | Device pin levels, bit s*4+i is slot s pin i |
| irq_line | output | 16 | Registered levels to the interrupt controller |

## Verification
The assertions check, on every cycle, the following:
- The reset values.
- That an out-of-window write leaves every steering byte unchanged and an in-window write stores its data.
- That the outputs are all low while every PIRQ is disabled.
- That no more lines are high than there were active PIRQs a cycle earlier.
- That the outputs hold still while neither levels nor steering move.

The exact mapping needs the bench's sweeps. These cover the slot rotation for every slot and pin, every steering value of every PIRQ, wired-OR sharing, re-steering, and the exact one- and two-edge latencies.

// File: rtl/intx_rt_pkg.sv
// Shared constants and types for the PCI shared interrupt line router.
// Assumes byte-wide steering registers and four INTx pins per device.
package intx_rt_pkg;

    // Width of one steering register
    localparam int ROUTE_W = 8;

    // Steering register contents
    typedef logic [ROUTE_W-1:0] route_t;

    // Shared line reached by pin `pin` of the device in slot `slot`
    function automatic int rotate_pin(int slot, int pin, int n_lines);
        return (pin + slot + n_lines - 1) % n_lines;
    endfunction

endpackage

// File: rtl/intx_swizzle.sv
// Collapses per-slot INTx pin levels onto the shared PIRQ lines.
// Pin i of slot s drives line (i + s - 1) mod NUM_PIRQ; a line is the OR of
// all pins that rotate onto it. Purely combinational.
module intx_swizzle #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_PIRQ  = 4
) (
    input  logic [NUM_SLOTS*NUM_PIRQ-1:0] dev_intx,
    output logic [NUM_PIRQ-1:0]           pirq_lvl
);
    import intx_rt_pkg::*;

    localparam int IN_W = NUM_SLOTS * NUM_PIRQ;

    // Constant mask of the input bits that feed one shared line
    function automatic logic [IN_W-1:0] feed_mask(int target);
        logic [IN_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int i = 0; i < NUM_PIRQ; i++) begin
                if (rotate_pin(s, i, NUM_PIRQ) == target) begin
                    m[s*NUM_PIRQ+i] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
        localparam logic [IN_W-1:0] FEED = feed_mask(p);
        // OR of every device pin rotated onto this shared line
        assign pirq_lvl[p] = |(dev_intx & FEED);
    end

endmodule

// File: rtl/intx_route_regs.sv
// Holds one steering byte per shared line and serves the byte-wide
// configuration port. Line p decodes at CFG_BASE + p. Writes elsewhere are
// dropped and reads elsewhere return zero. Stored bytes are returned unaltered.
module intx_route_regs #(
    parameter int          NUM_PIRQ  = 4,
    parameter int          ADDR_W    = 8,
    parameter int unsigned CFG_BASE  = 32'h60,
    parameter logic [7:0]  ROUTE_RST = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic                  cfg_wr_en,
    input  logic [7:0]            cfg_wr_data,
    output logic [7:0]            cfg_rd_data,
    output logic [NUM_PIRQ*8-1:0] route_flat
);
    import intx_rt_pkg::*;

    route_t route_q [NUM_PIRQ];

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + p);
        // Steering byte storage with reset to the disabled value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[p] <= ROUTE_RST;
            end else if (cfg_wr_en && cfg_addr == MY_ADDR) begin
                route_q[p] <= cfg_wr_data;
            end
        end
        assign route_flat[p*8 +: 8] = route_q[p];
    end

    // Read mux: selected steering byte, zero outside the window
    always_comb begin
        cfg_rd_data = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (cfg_addr == ADDR_W'(CFG_BASE + p)) begin
                cfg_rd_data = route_q[p];
            end
        end
    end

endmodule

// File: rtl/intx_line_merge.sv
// Builds the pending matrix (bit line*NUM_PIRQ + pirq) from the shared line
// levels and steering bytes, ORs each group per output and registers it.
// Assumes NUM_LINES is a power of two no larger than 128.
module intx_line_merge #(
    parameter int NUM_PIRQ  = 4,
    parameter int NUM_LINES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PIRQ-1:0]   pirq_lvl,
    input  logic [NUM_PIRQ*8-1:0] route_flat,
    output logic [NUM_LINES-1:0]  irq_line
);
    localparam int SEL_W   = $clog2(NUM_LINES);
    localparam int MATRIX_W = NUM_LINES * NUM_PIRQ;

    logic [NUM_PIRQ-1:0]  route_ok;
    logic [SEL_W-1:0]     route_sel [NUM_PIRQ];
    logic [MATRIX_W-1:0]  pending;
    logic [NUM_LINES-1:0] irq_next;
    logic [NUM_LINES-1:0] irq_q;

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_dec
        // A byte at or above NUM_LINES leaves the line unconnected
        assign route_ok[p]  = route_flat[p*8 +: 8] < 8'(NUM_LINES);
        assign route_sel[p] = route_flat[p*8 +: SEL_W];
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_src
            // One matrix bit per (output line, shared line) pair
            assign pending[l*NUM_PIRQ+p] = pirq_lvl[p] & route_ok[p]
                                         & (route_sel[p] == SEL_W'(l));
        end
        // Wired-OR of every source steered here
        assign irq_next[l] = |pending[l*NUM_PIRQ +: NUM_PIRQ];
    end

    // Output register, rebuilt from scratch each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_next;
        end
    end

    assign irq_line = irq_q;

endmodule

// File: rtl/pirq_intx_router.sv
// Top level of the PCI shared interrupt line router: slot rotation, steering
// registers and registered wired-OR merge. dev_intx bit s*NUM_PIRQ+i is pin i
// of slot s. Reset is synchronous and active low.
module pirq_intx_router #(
    parameter int          NUM_SLOTS = 8,
    parameter int          NUM_PIRQ  = 4,
    parameter int          NUM_LINES = 16,
    parameter int          ADDR_W    = 8,
    parameter int unsigned CFG_BASE  = 32'h60,
    parameter logic [7:0]  ROUTE_RST = 8'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic                          cfg_wr_en,
    input  logic [7:0]                    cfg_wr_data,
    output logic [7:0]                    cfg_rd_data,
    input  logic [NUM_SLOTS*NUM_PIRQ-1:0] dev_intx,
    output logic [NUM_LINES-1:0]          irq_line
);
    logic [NUM_PIRQ-1:0]   pirq_lvl;
    logic [NUM_PIRQ*8-1:0] route_flat;

    intx_swizzle #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_PIRQ  (NUM_PIRQ)
    ) u_swizzle (
        .dev_intx (dev_intx),
        .pirq_lvl (pirq_lvl)
    );

    intx_route_regs #(
        .NUM_PIRQ  (NUM_PIRQ),
        .ADDR_W    (ADDR_W),
        .CFG_BASE  (CFG_BASE),
        .ROUTE_RST (ROUTE_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_addr    (cfg_addr),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .route_flat  (route_flat)
    );

    intx_line_merge #(
        .NUM_PIRQ  (NUM_PIRQ),
        .NUM_LINES (NUM_LINES)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pirq_lvl   (pirq_lvl),
        .route_flat (route_flat),
        .irq_line   (irq_line)
    );

endmodule

// File: rtl/pirq_intx_router_chk.sv
// Property checker for pirq_intx_router, attached by bind. It watches the
// port, the shared line levels and the steering bytes.
module pirq_intx_router_chk #(
    parameter int          NUM_PIRQ  = 4,
    parameter int          NUM_LINES = 16,
    parameter int          ADDR_W    = 8,
    parameter int unsigned CFG_BASE  = 32'h60,
    parameter logic [7:0]  ROUTE_RST = 8'h80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     cfg_addr,
    input logic                  cfg_wr_en,
    input logic [7:0]            cfg_wr_data,
    input logic [NUM_LINES-1:0]  irq_line,
    input logic [NUM_PIRQ-1:0]   pirq_lvl,
    input logic [NUM_PIRQ*8-1:0] route_flat
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(CFG_BASE + NUM_PIRQ);

    logic                in_win;
    logic                all_off;
    logic [NUM_PIRQ-1:0] prev_lvl;

    assign in_win = (cfg_addr >= LO) && (cfg_addr < HI);

    // True while no shared line is steered anywhere
    always_comb begin
        all_off = 1'b1;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (route_flat[p*8 +: 8] < 8'(NUM_LINES)) all_off = 1'b0;
        end
    end

    // Shared line levels one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= pirq_lvl;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_line == '0 && route_flat == {NUM_PIRQ{ROUTE_RST}}));

    // R7
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !in_win) |=> $stable(route_flat));

    // R2
    first_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == LO) |=> route_flat[7:0] == $past(cfg_wr_data));

    // R3
    all_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> irq_line == '0);

    // R4
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_line) <= $countones(prev_lvl));

    // R6
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pirq_lvl) && $stable(route_flat)) |=> $stable(irq_line));

endmodule

bind pirq_intx_router pirq_intx_router_chk #(
    .NUM_PIRQ  (NUM_PIRQ),
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .CFG_BASE  (CFG_BASE),
    .ROUTE_RST (ROUTE_RST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_addr    (cfg_addr),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .irq_line    (irq_line),
    .pirq_lvl    (pirq_lvl),
    .route_flat  (route_flat)
);

// File: tb/test_pirq_intx_router.sv
`timescale 1ns/1ps
// Sweep bench for pirq_intx_router: every slot/pin, every steering value,
// sharing, re-steering and latency, against an arithmetic model.
module test_pirq_intx_router;
    localparam int NS = 8;
    localparam int NP = 4;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic          cfg_wr_en = 1'b0;
    logic [7:0]    cfg_wr_data = '0;
    logic [7:0]    cfg_rd_data;
    logic [NS*NP-1:0] dev_intx = '0;
    logic [NL-1:0] irq_line;

    logic [7:0] rt [NP];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    pirq_intx_router i_pirq_intx_router (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .dev_intx(dev_intx), .irq_line(irq_line)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Expected outputs from the stated rules (R3, R4, R5)
    function automatic logic [NL-1:0] expect_irq(logic [NS*NP-1:0] v);
        logic [NP-1:0] lvl;
        logic [NL-1:0] o;
        lvl = '0; o = '0;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < NP; i++)
                if (v[s*NP+i]) lvl[(i + s + 3) % 4] = 1'b1;
        for (int p = 0; p < NP; p++)
            if (lvl[p] && rt[p] < 8'd16) o[rt[p][3:0]] = 1'b1;
        return o;
    endfunction

    task automatic chk_irq(string req, logic [NL-1:0] exp);
        checks++;
        if (irq_line !== exp) begin
            errors++;
            $display("FAIL %s: irq_line got %h expected %h", req, irq_line, exp);
        end
    endtask

    task automatic chk_rd(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #0.5;
        checks++;
        if (cfg_rd_data !== exp) begin
            errors++;
            $display("FAIL %s: read %h got %h expected %h", req, a, cfg_rd_data, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the latching edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wr_data = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a >= 8'h60 && a < 8'h64) rt[a - 8'h60] = d;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic drive(logic [NS*NP-1:0] v);
        @(negedge clk);
        dev_intx = v;
        settle();
    endtask

    initial begin
        for (int p = 0; p < NP; p++) rt[p] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        chk_irq("R1", '0);
        for (int p = 0; p < NP; p++) chk_rd("R1", 8'(8'h60 + p), 8'h80);

        // R7: writes outside the window are dropped, reads there give zero
        wr(8'h5F, 8'h05); wr(8'h64, 8'h05); wr(8'h00, 8'h05);
        for (int p = 0; p < NP; p++) chk_rd("R7", 8'(8'h60 + p), 8'h80);
        chk_rd("R7", 8'h64, 8'h00);
        chk_rd("R7", 8'h5F, 8'h00);
        dev_intx = '1; settle(); settle();
        chk_irq("R7", '0);
        dev_intx = '0; settle();

        // R2: stored bytes read back unaltered
        wr(8'h60, 8'hA7); wr(8'h61, 8'h10); wr(8'h62, 8'hFF); wr(8'h63, 8'h0E);
        chk_rd("R2", 8'h60, 8'hA7);
        chk_rd("R2", 8'h61, 8'h10);
        chk_rd("R2", 8'h62, 8'hFF);
        chk_rd("R2", 8'h63, 8'h0E);

        // R5: every slot and pin, one at a time, PIRQp on line 4p+1
        for (int p = 0; p < NP; p++) wr(8'(8'h60 + p), 8'(4 * p + 1));
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < NP; i++) begin
                logic [NS*NP-1:0] v;
                v = '0; v[s*NP+i] = 1'b1;
                drive(v);
                chk_irq("R5", expect_irq(v));
            end
        end
        drive('0);

        // R3: every steering value of every PIRQ, all pins active
        for (int p = 0; p < NP; p++) wr(8'(8'h60 + p), 8'h80);
        dev_intx = '1;
        for (int p = 0; p < NP; p++) begin
            for (int val = 0; val < 34; val++) begin
                logic [7:0] b;
                b = (val == 32) ? 8'h80 : (val == 33) ? 8'hFF : 8'(val);
                wr(8'(8'h60 + p), b);
                settle();
                chk_irq("R3", (b < 8'd16) ? (16'h1 << b[3:0]) : 16'h0);
            end
            wr(8'(8'h60 + p), 8'h80);
        end
        drive('0);

        // R4: PIRQ0 (slot1 pin0) and PIRQ1 (slot1 pin1) shared on line 7
        wr(8'h60, 8'd7); wr(8'h61, 8'd7);
        for (int m = 0; m < 4; m++) begin
            logic [NS*NP-1:0] v;
            v = '0; v[4] = m[0]; v[5] = m[1];
            drive(v);
            chk_irq("R4", (m != 0) ? 16'h0080 : 16'h0000);
        end
        // R4: one line set off while its partner stays live
        wr(8'h61, 8'h90); settle();
        chk_irq("R4", 16'h0080);
        drive('0);

        // R8: PIRQ2 (slot 0 pin 3) moves from line 3 to line 11
        wr(8'h62, 8'd3);
        drive(32'h0000_0008);
        chk_irq("R8", 16'h0008);
        wr(8'h62, 8'd11); settle();
        chk_irq("R8", 16'h0800);

        // R6: input latency of one edge
        drive('0);
        @(negedge clk);
        dev_intx = 32'h0000_0008;
        #0.5 chk_irq("R6", 16'h0000);
        settle();
        chk_irq("R6", 16'h0800);
        // R6: write latency, outputs follow one edge after the register
        wr(8'h62, 8'd12);
        chk_irq("R6", 16'h0800);
        settle();
        chk_irq("R6", 16'h1000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule